// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table in memory. A request carries the linear address, the current privilege level (0 to 3) and a write flag. A directory base value, sampled when the request is accepted, points at the top-level table. The walker issues two reads on a plain read port: the first fetches the directory entry and the second fetches the table entry.

After each read, the walker checks the entry's present bit and then its access rights. If either level fails, the walk stops. The block then reports a not-present fault or a protection fault, and copies the whole faulting linear address into a fault-address register. If both levels pass, a one-cycle completion pulse delivers the physical address.

The walk runs through seven named states:
- IDLE accepts a request (IDLE→READ_PDE).
- READ_PDE holds the read until data arrives (→CHECK_PDE).
- CHECK_PDE goes to FAULT on a bad entry, or else to READ_PTE.
- READ_PTE waits for its data (→CHECK_PTE).
- CHECK_PTE goes to FAULT, or else to DONE.
- DONE and FAULT each last one cycle and return to IDLE.

Top module: `pt_walker`

## Requirements
- R1: A synchronous reset returns the walker to IDLE. While idle after reset there is no completion pulse and no read request, and the fault-address register reads zero.
- R2: The first read goes to the directory base plus four times linear bits [31:22], computed as a full 32-bit addition.
- R3: The second read goes to the directory entry's bits [31:12] followed by twelve zero bits, plus four times linear bits [21:12].
- R4: A directory entry whose bit 0 is 0 ends the walk with the not-present flag and no second read. The physical address output reads zero. The not-present result takes priority over any permission result.
- R5: A table entry whose bit 0 is 0 ends the walk with the not-present flag, and the physical address output reads zero.
- R6: A successful walk raises the completion output for exactly one cycle. In that cycle both fault flags are low and the physical address is table-entry bits [31:12] followed by linear bits [11:0].
- R7: Any fault loads the full linear address into the fault-address register, where it is visible in the completion cycle. Successful walks leave that register unchanged.
- R8: At privilege level 3, an entry at either level whose bit 2 is 0 causes a protection fault.
- R9: At privilege level 3, a write through an entry at either level whose bit 1 is 0 causes a protection fault. Levels 0 to 2 ignore bits 1 and 2.
- R10: A request is taken only in IDLE. A request presented while a walk is in progress has no effect on that walk or its result.
- R11: A read request and its address are held steady until the read-data strobe arrives, for any response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe |
| req_lin | input | 32 | Linear address to translate |
| req_cpl | input | 2 | Current privilege level, 3 = user |
| req_write | input | 1 | Access is a write |
| dir_base | input | 32 | Directory base address, sampled on acceptance |
| mem_rd_req | output | 1 | Read request, held until data returns |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_data | input | 32 | Returned entry |
| mem_rd_valid | input | 1 | Returned entry is valid |
| busy | output | 1 | Walk in progress (not IDLE) |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Physical address, valid with done on success |
| done_np_fault | output | 1 | With done: an entry was not present |
| done_prot_fault | output | 1 | With done: permission violation |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
The bench places entries so that the index fields sit at their maximum values and the directory base is not page-aligned. A walker that concatenated instead of adding, or shifted the index wrongly, would fetch the wrong word and report the wrong fault or address.

It pairs entries whose present bit is clear with permission bits that are also clear. A walker that checked rights before presence would then raise the protection flag instead of the not-present flag.

It also:
- Alternates user and supervisor writes through read-only entries, which catches a privilege test that is inverted or applied to supervisors.
- Interleaves successful walks with faults, which exposes a fault register that updates on every walk.
- Presents a second request during a walk under a slow memory, which exposes a walker that accepts mid-walk or drops its read request early.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
    localparam int PW_AW      = 32;
    localparam int PW_IDX_W   = 10;
    localparam int PW_OFF_W   = 12;
    localparam int PW_ESH     = 2;
    localparam int PW_LEVELS  = 2;
    localparam int PW_P_BIT   = 0;
    localparam int PW_RW_BIT  = 1;
    localparam int PW_US_BIT  = 2;
    localparam logic [1:0] PW_USER_CPL = 2'd3;

    typedef enum logic [2:0] {
        IDLE      = 3'd0,
        READ_PDE  = 3'd1,
        CHECK_PDE = 3'd2,
        READ_PTE  = 3'd3,
        CHECK_PTE = 3'd4,
        DONE      = 3'd5,
        FAULT     = 3'd6
    } pw_state_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int AW    = pt_walk_pkg::PW_AW,
    parameter int IDX_W = pt_walk_pkg::PW_IDX_W,
    parameter int OFF_W = pt_walk_pkg::PW_OFF_W,
    parameter int ESH   = pt_walk_pkg::PW_ESH
) (
    input  logic [AW-1:0]       base_addr,
    input  logic [AW-1:0]       lin_addr,
    input  logic [AW-OFF_W-1:0] tbl_frame,
    input  logic [AW-OFF_W-1:0] page_frame,
    output logic [AW-1:0]       dir_ent_addr,
    output logic [AW-1:0]       tbl_ent_addr,
    output logic [AW-1:0]       phys_addr
);
    localparam int PAD_W = AW - IDX_W - ESH;
    localparam int HI_LO = AW - IDX_W;
    localparam int MI_LO = OFF_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = lin_addr[AW-1:HI_LO];
    assign tbl_idx = lin_addr[MI_LO+IDX_W-1:MI_LO];

    assign dir_ent_addr = base_addr + {{PAD_W{1'b0}}, dir_idx, {ESH{1'b0}}};
    assign tbl_ent_addr = {tbl_frame, {OFF_W{1'b0}}}
                        + {{PAD_W{1'b0}}, tbl_idx, {ESH{1'b0}}};
    assign phys_addr    = {page_frame, lin_addr[OFF_W-1:0]};
endmodule

// File: rtl/pw_entry_chk.sv
module pw_entry_chk #(
    parameter int AW    = pt_walk_pkg::PW_AW,
    parameter int OFF_W = pt_walk_pkg::PW_OFF_W
) (
    input  logic [AW-1:0]       entry,
    input  logic                is_user,
    input  logic                is_write,
    output logic                present,
    output logic                perm_ok,
    output logic [AW-OFF_W-1:0] frame
);
    import pt_walk_pkg::*;

    logic unused_entry_bits;
    assign unused_entry_bits = ^entry[OFF_W-1:PW_US_BIT+1];

    assign present = entry[PW_P_BIT];
    assign frame   = entry[AW-1:OFF_W];

    always_comb begin
        perm_ok = 1'b1;
        if (is_user) begin
            if (!entry[PW_US_BIT])
                perm_ok = 1'b0;
            if (is_write && !entry[PW_RW_BIT])
                perm_ok = 1'b0;
        end
    end
endmodule

// File: rtl/pw_fault_reg.sv
module pw_fault_reg #(
    parameter int AW = pt_walk_pkg::PW_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int AW    = pt_walk_pkg::PW_AW,
    parameter int OFF_W = pt_walk_pkg::PW_OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_lin,
    input  logic [1:0]    req_cpl,
    input  logic          req_write,
    input  logic [AW-1:0] dir_base,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [AW-1:0] mem_rd_data,
    input  logic          mem_rd_valid,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] done_pa,
    output logic          done_np_fault,
    output logic          done_prot_fault,
    output logic [AW-1:0] fault_addr
);
    import pt_walk_pkg::*;

    localparam int FR_W = AW - OFF_W;

    pw_state_e state, state_nx;

    logic [AW-1:0] lin_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cpl_q;
    logic          wr_q;
    logic          np_q;
    logic          prot_q;
    logic [AW-1:0] ent_q [PW_LEVELS];

    logic [PW_LEVELS-1:0] lvl_present;
    logic [PW_LEVELS-1:0] lvl_perm_ok;
    logic [FR_W-1:0]      lvl_frame [PW_LEVELS];

    logic [AW-1:0] dir_ent_addr;
    logic [AW-1:0] tbl_ent_addr;
    logic [AW-1:0] phys_addr;
    logic          is_user;
    logic          fault_load;
    logic          chk_bad;

    assign is_user = (cpl_q == PW_USER_CPL);

    for (genvar lv = 0; lv < PW_LEVELS; lv++) begin : g_lvl
        pw_entry_chk #(.AW(AW), .OFF_W(OFF_W)) i_chk (
            .entry    (ent_q[lv]),
            .is_user  (is_user),
            .is_write (wr_q),
            .present  (lvl_present[lv]),
            .perm_ok  (lvl_perm_ok[lv]),
            .frame    (lvl_frame[lv])
        );
    end

    pw_addr_gen #(.AW(AW), .OFF_W(OFF_W)) i_addr (
        .base_addr    (base_q),
        .lin_addr     (lin_q),
        .tbl_frame    (lvl_frame[0]),
        .page_frame   (lvl_frame[1]),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .phys_addr    (phys_addr)
    );

    always_comb begin
        chk_bad = 1'b0;
        if (state == CHECK_PDE)
            chk_bad = !lvl_present[0] || !lvl_perm_ok[0];
        else if (state == CHECK_PTE)
            chk_bad = !lvl_present[1] || !lvl_perm_ok[1];
    end

    assign fault_load = chk_bad;

    pw_fault_reg #(.AW(AW)) i_freg (
        .clk  (clk),
        .rst  (rst),
        .load (fault_load),
        .din  (lin_q),
        .q    (fault_addr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:      if (req_valid) state_nx = READ_PDE;
            READ_PDE:  if (mem_rd_valid) state_nx = CHECK_PDE;
            CHECK_PDE: state_nx = chk_bad ? FAULT : READ_PTE;
            READ_PTE:  if (mem_rd_valid) state_nx = CHECK_PTE;
            CHECK_PTE: state_nx = chk_bad ? FAULT : DONE;
            DONE:      state_nx = IDLE;
            FAULT:     state_nx = IDLE;
            default:   state_nx = IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= IDLE;
        else
            state <= state_nx;
    end

    // walk context and fetched entries
    always_ff @(posedge clk) begin
        if (rst) begin
            lin_q  <= '0;
            base_q <= '0;
            cpl_q  <= '0;
            wr_q   <= 1'b0;
            np_q   <= 1'b0;
            prot_q <= 1'b0;
            for (int i = 0; i < PW_LEVELS; i++)
                ent_q[i] <= '0;
        end else begin
            if (state == IDLE && req_valid) begin
                lin_q  <= req_lin;
                base_q <= dir_base;
                cpl_q  <= req_cpl;
                wr_q   <= req_write;
                np_q   <= 1'b0;
                prot_q <= 1'b0;
            end
            if (state == READ_PDE && mem_rd_valid)
                ent_q[0] <= mem_rd_data;
            if (state == READ_PTE && mem_rd_valid)
                ent_q[1] <= mem_rd_data;
            if (state == CHECK_PDE && chk_bad) begin
                np_q   <= !lvl_present[0];
                prot_q <= lvl_present[0];
            end
            if (state == CHECK_PTE && chk_bad) begin
                np_q   <= !lvl_present[1];
                prot_q <= lvl_present[1];
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_req      = 1'b0;
        mem_rd_addr     = '0;
        done            = 1'b0;
        done_pa         = '0;
        done_np_fault   = 1'b0;
        done_prot_fault = 1'b0;
        busy            = (state != IDLE);
        unique case (state)
            READ_PDE: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = dir_ent_addr;
            end
            READ_PTE: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = tbl_ent_addr;
            end
            DONE: begin
                done    = 1'b1;
                done_pa = phys_addr;
            end
            FAULT: begin
                done            = 1'b1;
                done_np_fault   = np_q;
                done_prot_fault = prot_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int AW = pt_walk_pkg::PW_AW
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] done_pa,
    input logic          done_np_fault,
    input logic          done_prot_fault,
    input logic [AW-1:0] fault_addr,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_valid
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fault_addr == '0 && !busy && !done && !mem_rd_req));

    p_np_no_pa_r4: assert property (@(posedge clk) disable iff (rst)
        (done && done_np_fault) |-> (done_pa == '0 && !done_prot_fault));

    p_flags_need_done_r6: assert property (@(posedge clk) disable iff (rst)
        (done_np_fault || done_prot_fault) |-> done);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fa_only_on_fault_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        !$stable(fault_addr) |-> (done && (done_np_fault || done_prot_fault)));

    p_rd_only_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> busy);

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) i_pt_walker_chk (
    .clk             (clk),
    .rst             (rst),
    .busy            (busy),
    .done            (done),
    .done_pa         (done_pa),
    .done_np_fault   (done_np_fault),
    .done_prot_fault (done_prot_fault),
    .fault_addr      (fault_addr),
    .mem_rd_req      (mem_rd_req),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rd_valid    (mem_rd_valid)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic [1:0]  req_cpl = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_valid = 1'b0;
    logic        busy, done, done_np_fault, done_prot_fault;
    logic [31:0] done_pa, fault_addr;

    pt_walker i_pt_walker (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] pa;
        logic        np;
        logic        prot;
        logic [31:0] fa;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] model_fa = '0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model, answers after lat extra cycles
    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
            wait_cnt     <= 0;
        end else if (mem_rd_req) begin
            if (wait_cnt >= lat) begin
                if (addr_q.size() == 0) begin
                    check("R2/R3 unexpected read", mem_rd_addr, 32'hFFFF_FFFF);
                end else begin
                    check("R2/R3 entry address", mem_rd_addr, addr_q.pop_front());
                end
                mem_rd_data  <= rd(mem_rd_addr);
                mem_rd_valid <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected done", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " pa"}, done_pa, e.pa);
                check({e.tag, " np flag"}, {31'b0, done_np_fault}, {31'b0, e.np});
                check({e.tag, " prot flag"}, {31'b0, done_prot_fault}, {31'b0, e.prot});
                check({e.tag, " fault_addr R7"}, fault_addr, e.fa);
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] lin, input logic [1:0] cpl,
                        input logic wr, input logic [31:0] base, input int l, input bit junk);
        exp_t        e;
        logic [31:0] pde, pte, a0, a1;
        bit          usr;
        usr = (cpl == 2'd3);
        a0 = base + {20'b0, lin[31:22], 2'b00};
        pde = rd(a0);
        addr_q.push_back(a0);
        e.pa = '0; e.np = 0; e.prot = 0; e.tag = tag;
        if (!pde[0]) e.np = 1;
        else if (usr && (!pde[2] || (wr && !pde[1]))) e.prot = 1;
        else begin
            a1 = {pde[31:12], 12'h0} + {20'b0, lin[21:12], 2'b00};
            pte = rd(a1);
            addr_q.push_back(a1);
            if (!pte[0]) e.np = 1;
            else if (usr && (!pte[2] || (wr && !pte[1]))) e.prot = 1;
            else e.pa = {pte[31:12], lin[11:0]};
        end
        if (e.np || e.prot) model_fa = lin;
        e.fa = model_fa;
        exp_q.push_back(e);
        lat = l;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_cpl = cpl; req_write = wr; dir_base = base;
        @(negedge clk);
        if (junk) begin
            // R10: a different request held during the walk
            req_lin = ~lin; req_cpl = 2'd0; req_write = ~wr; dir_base = base + 32'h40;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check({tag, " R6 done one cycle"}, {31'b0, done}, 32'h0);
    endtask

    localparam logic [31:0] B = 32'h0001_0040;

    initial begin
        // directory entries
        mem[B + 32'h4] = 32'h0002_0007;              // idx1 -> table 0x20000, user rw
        mem[B + 32'h8] = 32'h0000_0006;              // idx2 not present, rights set
        mem[B + 32'hC] = 32'h0003_0003;              // idx3 supervisor-only
        mem[B + 32'h10] = 32'h0004_0005;             // idx4 user read-only
        mem[B + 32'hFFC] = 32'h0005_0007;            // idx 0x3FF
        // tables
        mem[32'h0002_0000 + 32'h14] = 32'hABCD_E007; // idx5 user rw
        mem[32'h0002_0000 + 32'h18] = 32'h1234_5006; // idx6 not present
        mem[32'h0002_0000 + 32'h1C] = 32'h2222_2003; // idx7 supervisor-only
        mem[32'h0002_0000 + 32'h20] = 32'h3333_3005; // idx8 read-only
        mem[32'h0003_0000 + 32'h14] = 32'h4444_4007;
        mem[32'h0004_0000 + 32'h14] = 32'h5555_5007;
        mem[32'h0005_0000 + 32'hFFC] = 32'h7777_7001;

        repeat (3) @(negedge clk);
        check("R1 fault_addr after reset", fault_addr, 32'h0);
        check("R1 busy after reset", {31'b0, busy}, 32'h0);
        check("R1 rd req after reset", {31'b0, mem_rd_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done idle", {31'b0, done}, 32'h0);

        walk("R6 sup read", 32'h0040_5ABC, 2'd0, 0, B, 0, 0);
        walk("R4 pde absent", 32'h0080_1123, 2'd3, 1, B, 1, 0);
        walk("R6 R7 hold after fault", 32'h0040_5001, 2'd3, 1, B, 2, 0);
        walk("R5 pte absent", 32'h0040_6FFF, 2'd1, 0, B, 0, 0);
        walk("R8 pde user denied", 32'h00C0_5000, 2'd3, 0, B, 0, 0);
        walk("R8 sup ok pde", 32'h00C0_5010, 2'd2, 1, B, 0, 0);
        walk("R8 pte user denied", 32'h0040_7008, 2'd3, 0, B, 1, 0);
        walk("R9 pde user write", 32'h0100_5004, 2'd3, 1, B, 0, 0);
        walk("R9 pde user read ok", 32'h0100_5004, 2'd3, 0, B, 0, 0);
        walk("R9 pte user write", 32'h0040_8100, 2'd3, 1, B, 0, 0);
        walk("R9 pte sup write ok", 32'h0040_8100, 2'd0, 1, B, 0, 0);
        walk("R10 R11 busy ignore", 32'h0040_5333, 2'd3, 1, B, 3, 1);
        walk("R2 R3 max index", 32'hFFFF_FFFF, 2'd0, 0, B, 1, 0);
        walk("R4 R10 after junk", 32'h0080_2000, 2'd0, 0, B, 4, 1);

        check("R2/R3 all reads issued", addr_q.size(), 0);
        check("R6 all results seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule